// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell

This block sits beside a two-port shared memory of 1024 words and gives the two sides a way to signal each other. One word at the top of the address space is the inbox of the right side and the word just below it is the inbox of the left side. When one side stores a word into the other side's inbox, the receiving side sees its active-low doorbell line go low. The receiver reads its inbox, and that read clears its own doorbell. The inbox words are still ordinary memory words, so the block only watches the port strobes and addresses. It never drives data.

Each side presents the same active-low controls as the memory: select, write strobe (low means write, high means read) and output enable, plus an address. The block samples these on the rising edge of a single clock. It updates the doorbell registers one edge after a qualifying access.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, both `lIrqN` and `rIrqN` are high (no doorbell pending).
- R2: A left write to address 0x3FF drives `rIrqN` low at the next clock edge. A write means `lSelN`=0 and `lWrN`=0.
- R3: A right read of address 0x3FF drives `rIrqN` high at the next clock edge. A read means `rSelN`=0, `rOeN`=0 and `rWrN`=1.
- R4: A right write to address 0x3FE drives `lIrqN` low at the next clock edge.
- R5: A left read of address 0x3FE drives `lIrqN` high at the next clock edge.
- R6: A doorbell is raised only when the writer's select and write strobe are both low. A write-strobe pulse while deselected, or a deselected cycle, leaves both doorbells unchanged.
- R7: A doorbell is cleared only when the reader's select and output enable are both low during a read. A read with the output enable high, or while deselected, leaves the doorbell pending.
- R8: If a raise and a clear of the same doorbell occur in the same cycle, the doorbell ends low (raise wins).
- R9: A side writing its own inbox, reading the other side's inbox, or accessing any other address changes neither doorbell.
- R10: A doorbell keeps its value on every edge that has no qualifying raise or clear for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses are sampled on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| lSelN | input | 1 | Left select, active low |
| lWrN | input | 1 | Left write strobe, low = write, high = read |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | 10 | Left word address |
| rSelN | input | 1 | Right select, active low |
| rWrN | input | 1 | Right write strobe, low = write, high = read |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | 10 | Right word address |
| lIrqN | output | 1 | Left doorbell, low while a message waits at 0x3FE |
| rIrqN | output | 1 | Right doorbell, low while a message waits at 0x3FF |

## Verification
Every doorbell result is due exactly one rising edge after the access that causes it. No other register lies between the port strobes and the output flop. The driver applies each access on a falling edge and lets one rising edge pass. It then queues the expected pair of doorbell levels. The monitor compares that pair on the next falling edge, so each comparison sees the outputs of the one edge the access produced. Idle and ineffective cycles queue unchanged expectations. This checks that the doorbells hold their value between events.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NUM_SIDES = 2;   // index 0 = left, 1 = right

  typedef struct packed {
    logic [NUM_SIDES-1:0] raise;  // raise doorbell of side i
    logic [NUM_SIDES-1:0] clear;  // clear doorbell of side i
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_SIDES-1:0]                 selN,
  input  logic [NUM_SIDES-1:0]                 wrN,
  input  logic [NUM_SIDES-1:0]                 oeN,
  input  logic [NUM_SIDES-1:0][ADDR_W-1:0]     addr,
  output mboxStrobes_t                         strobes
);
  localparam logic [ADDR_W-1:0] TOP_WORD  = '1;
  localparam logic [ADDR_W-1:0] NEXT_WORD = TOP_WORD - 1'b1;

  logic [NUM_SIDES-1:0] isWrite;
  logic [NUM_SIDES-1:0] isRead;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : gSide
    localparam int PEER = NUM_SIDES - 1 - s;
    // right inbox is the top word, left inbox the word below it
    localparam logic [ADDR_W-1:0] INBOX = (s == 1) ? TOP_WORD : NEXT_WORD;

    assign isWrite[s] = !selN[s] && !wrN[s];
    assign isRead[s]  = !selN[s] && !oeN[s] && wrN[s];

    assign strobes.raise[s] = isWrite[PEER] && (addr[PEER] == INBOX);
    assign strobes.clear[s] = isRead[s]     && (addr[s]    == INBOX);
  end

  // a side cannot both ring the peer and drain its own inbox in one cycle
  AST_SIDE_ONE_ACCESS_L: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.raise[1] && strobes.clear[0])); // R9
  AST_SIDE_ONE_ACCESS_R: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.raise[0] && strobes.clear[1])); // R9
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  mboxStrobes_t         strobes,
  output logic [NUM_SIDES-1:0] irqN
);
  for (genvar s = 0; s < NUM_SIDES; s++) begin : gFlag
    logic pending;

    always_ff @(posedge clk) begin
      if (!rstN)                  pending <= 1'b0;
      else if (strobes.raise[s])  pending <= 1'b1;
      else if (strobes.clear[s])  pending <= 1'b0;
    end

    assign irqN[s] = ~pending;

    AST_RAISE_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
      strobes.raise[s] |=> !irqN[s]); // R8
    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clear[s] && !strobes.raise[s]) |=> irqN[s]); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.clear[s] && !strobes.raise[s]) |=> $stable(irqN[s])); // R10
  end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSelN,
  input  logic              lWrN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rSelN,
  input  logic              rWrN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  output logic              lIrqN,
  output logic              rIrqN
);
  mboxStrobes_t         strobes;
  logic [NUM_SIDES-1:0] irqN;

  mbox_decode #(.ADDR_W(ADDR_W)) uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .selN    ({rSelN, lSelN}),
    .wrN     ({rWrN, lWrN}),
    .oeN     ({rOeN, lOeN}),
    .addr    ({rAddr, lAddr}),
    .strobes (strobes)
  );

  mbox_flags uFlags (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .irqN    (irqN)
  );

  assign lIrqN = irqN[0];
  assign rIrqN = irqN[1];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (lIrqN && rIrqN)); // R1
endmodule

// File: tb/tb_mbox_doorbell.sv
module tb_mbox_doorbell;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam logic [AW-1:0] R_BOX = 10'h3FF;
  localparam logic [AW-1:0] L_BOX = 10'h3FE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSelN = 1'b1, lWrN = 1'b1, lOeN = 1'b1;
  logic rSelN = 1'b1, rWrN = 1'b1, rOeN = 1'b1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic lIrqN, rIrqN;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic expL = 1'b1, expR = 1'b1;
  logic [1:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_doorbell #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN),
    .lSelN(lSelN), .lWrN(lWrN), .lOeN(lOeN), .lAddr(lAddr),
    .rSelN(rSelN), .rWrN(rWrN), .rOeN(rOeN), .rAddr(rAddr),
    .lIrqN(lIrqN), .rIrqN(rIrqN)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  // driver: apply one cycle on both sides, then queue the expected levels
  task automatic access(input logic ls, input logic lw, input logic lo, input logic [AW-1:0] la,
                        input logic rs, input logic rw, input logic ro, input logic [AW-1:0] ra,
                        input string tag);
    logic lWrite, lRead, rWrite, rRead;
    @(negedge clk);
    lSelN = ls; lWrN = lw; lOeN = lo; lAddr = la;
    rSelN = rs; rWrN = rw; rOeN = ro; rAddr = ra;
    lWrite = !ls && !lw;  lRead = !ls && !lo && lw;
    rWrite = !rs && !rw;  rRead = !rs && !ro && rw;
    if (lWrite && la == R_BOX)     expR = 1'b0;
    else if (rRead && ra == R_BOX) expR = 1'b1;
    if (rWrite && ra == L_BOX)     expL = 1'b0;
    else if (lRead && la == L_BOX) expL = 1'b1;
    @(posedge clk);
    #1;
    expQ.push_back({expL, expR});
    tagQ.push_back(tag);
  endtask

  task automatic idle(input string tag);
    access(1, 1, 1, '0, 1, 1, 1, '0, tag);
  endtask

  // monitor: compare the outputs of the edge each queued item belongs to
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({lIrqN, rIrqN} !== e) begin
        fails++;
        $display("FAIL %s: actual l=%b r=%b expected l=%b r=%b", t, lIrqN, rIrqN, e[1], e[0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({lIrqN, rIrqN} !== 2'b11) begin
      fails++;
      $display("FAIL R1: actual l=%b r=%b expected l=1 r=1", lIrqN, rIrqN);
    end
    rstN = 1'b1;
    idle("R1");
    // R2 / R3
    access(0, 0, 1, R_BOX, 1, 1, 1, '0, "R2");
    idle("R10");
    idle("R10");
    access(0, 1, 0, R_BOX, 1, 1, 1, '0, "R9 left reads peer inbox");
    access(1, 1, 1, '0, 0, 0, 1, R_BOX, "R9 right writes own inbox");
    access(1, 1, 1, '0, 0, 1, 1, R_BOX, "R7 oe high");
    access(1, 1, 1, '0, 1, 1, 0, R_BOX, "R7 deselected");
    access(1, 1, 1, '0, 0, 1, 0, R_BOX, "R3");
    // R4 / R5
    access(1, 1, 1, '0, 0, 0, 1, L_BOX, "R4");
    idle("R10");
    access(0, 0, 1, L_BOX, 1, 1, 1, '0, "R9 left writes own inbox");
    access(1, 1, 1, '0, 0, 1, 0, L_BOX, "R9 right reads peer inbox");
    access(0, 1, 1, L_BOX, 1, 1, 1, '0, "R7 oe high");
    access(0, 1, 0, L_BOX, 1, 1, 1, '0, "R5");
    // R6
    access(1, 0, 1, R_BOX, 1, 0, 1, L_BOX, "R6 deselected write");
    access(0, 1, 1, R_BOX, 0, 1, 1, L_BOX, "R6 no write strobe");
    // R9 other addresses
    access(0, 0, 1, 10'h155, 0, 0, 1, 10'h2AA, "R9 other address");
    access(0, 0, 1, 10'h1FF, 0, 0, 1, 10'h3FD, "R9 near miss");
    // R8 set wins, from pending and from idle states
    access(0, 0, 1, R_BOX, 0, 0, 1, L_BOX, "R2 R4 both ring");
    access(0, 0, 1, R_BOX, 0, 1, 0, R_BOX, "R8 right side");
    access(0, 1, 0, L_BOX, 0, 0, 1, L_BOX, "R8 left side");
    access(0, 1, 0, L_BOX, 0, 1, 0, R_BOX, "R3 R5 both clear");
    access(0, 0, 1, R_BOX, 0, 1, 0, R_BOX, "R8 from idle");
    access(0, 1, 0, L_BOX, 0, 1, 0, R_BOX, "R3");
    // reset while pending
    access(0, 0, 1, R_BOX, 0, 0, 1, L_BOX, "R2 R4");
    @(negedge clk);
    rstN = 1'b0;
    expL = 1'b1; expR = 1'b1;
    idle("R1 reset clears");
    rstN = 1'b1;
    idle("R1");
    repeat (3) @(negedge clk);
    finished = 1;
    summary();
  end
endmodule